// File: doc/BRIEF.md
# Variable-Width FIFO SPI Master

This block is a register-mapped SPI master for a single slave. Software queues transfers into a four-entry transmit queue and collects what came back from a four-entry receive queue. Every queued entry carries its own shift length of 1 to 24 bits, so one register write can move a single bit, a byte or three bytes. The address used for a transmit write decides what chip select does after that entry: the hold address keeps the slave selected so that the next entry continues the same frame, while the data address ends the frame once the entry has shifted out.

The serial clock comes from a 12-bit divider. Clock polarity, the launch phase and the capture phase are set separately, and so is the bit order for each direction. After every entry the shifter leaves one idle serial clock period before it starts the next. An interrupt line combines a transmit-queue-empty condition and an idle condition, each with its own enable.

The register bus accepts every access in the cycle it is presented and never stalls. Back-pressure is left to software: a transmit write that meets a full queue is dropped, and a receive pop from an empty queue returns zero. Software reads the status levels before it pushes or pops.

Top module: `spim_top`

## Requirements
- R1: After reset chip select is high, the serial clock is low, the interrupt is low and the status register (0x08) reads 0x0000_0280: both queues are empty, the transmit-empty flag is bit 9 and the receive-empty flag is bit 7.
- R2: When variable-width mode (control 0 bit 14) is set, bits 31:24 of a transmit write give the bit count and bits 23:0 hold the payload. A count of 0 is treated as 1 and a count above 24 as 24.
- R3: When bit 14 of control 0 is clear, the count comes from control 0 bits 5:0, with the same limits as in R2.
- R4: Each half period of the serial clock lasts divider+1 system clocks, where the divider is control 0 bits 31:20.
- R5: The serial clock idles at the polarity bit (control 0 bit 7). When the launch-phase bit (bit 8) is clear, data changes on trailing edges; when it is set, data changes on leading edges. The capture-phase bit (bit 10) selects sampling on the trailing edge (set) or on the leading edge (clear).
- R6: With control 0 bit 6 set, the payload goes out from bit 23 downward; otherwise it goes out from bit 0 upward. With control 1 bit 1 set, received bits are shifted in at bit 0 so that the result is right-aligned; otherwise each bit enters at bit 23 and the register shifts right.
- R7: An entry written at 0x30 leaves chip select low when it completes. An entry written at 0x20 raises chip select when it completes.
- R8: After the last trailing edge of an entry, the next entry's first leading edge comes three half periods later, one serial clock period more than between bits.
- R9: A read at 0x20 returns the oldest received word in bits 23:0 and removes it from the queue. A read at 0x0C returns the same word and leaves the queue unchanged. Both addresses return 0 when the queue is empty.
- R10: A transmit write to a full queue is dropped. The status register shows the transmit level in bits 31:24, the receive level in bits 23:16, transmit full in bit 10, receive full in bit 8, busy in bit 6 and the current bit count in bits 5:0.
- R11: Writing control 0 with bit 9 set empties both queues and returns the shifter to idle with chip select high.
- R12: While the enable bit (control 0 bit 11) is clear, the shifter stays idle with chip select high and queued entries remain waiting.
- R13: The interrupt is high when control 1 bit 6 is set and the transmit queue is empty, or when control 1 bit 7 is set and the shifter is not busy.
- R14: With control 1 bit 0 set, the receive shift register is not cleared at the start of an entry, so the bits from earlier entries stay in its upper part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, accepted in the same cycle |
| bus_rd | input | 1 | Register read strobe; a read at 0x20 pops the receive queue |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle bus_rd is high |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |
| spi_cs_n | output | 1 | Active-low chip select |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check four things on every cycle: the queue levels never pass their depth, a clear or a dropped enable leaves chip select high in the next cycle, the serial clock rests at its polarity whenever the shifter is idle, and an enabled idle interrupt is raised as soon as busy falls. Other behaviour can only be shown by the bench's scenarios. These include the bit order and edge choice for each mode combination (checked through a loopback), the length limits, the choice between holding and releasing chip select by address, the extra idle period between entries, peek against pop, and how the receive register accumulates across entries when it is not cleared.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int DATA_W = 24;
  localparam int LEN_W  = 5;

  localparam logic [7:0] A_CTRL0 = 8'h00;
  localparam logic [7:0] A_CTRL1 = 8'h04;
  localparam logic [7:0] A_STAT  = 8'h08;
  localparam logic [7:0] A_PEEK  = 8'h0C;
  localparam logic [7:0] A_DATA  = 8'h20;
  localparam logic [7:0] A_HOLD  = 8'h30;

  localparam int C0_VARW  = 14;
  localparam int C0_EN    = 11;
  localparam int C0_PHI   = 10;
  localparam int C0_CLR   = 9;
  localparam int C0_PHO   = 8;
  localparam int C0_POL   = 7;
  localparam int C0_MSBO  = 6;
  localparam int C1_IDLIE = 7;
  localparam int C1_TXEIE = 6;
  localparam int C1_MSBI  = 1;
  localparam int C1_KEEP  = 0;

  typedef struct packed {
    logic              hold;
    logic [LEN_W-1:0]  len;
    logic [DATA_W-1:0] data;
  } tx_entry_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_GAP} sh_state_t;

  function automatic logic [LEN_W-1:0] clamp_len(input logic [7:0] raw);
    if (raw == 8'd0) return LEN_W'(1);
    if (raw > 8'(DATA_W)) return LEN_W'(DATA_W);
    return raw[LEN_W-1:0];
  endfunction
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      if (do_push && !do_pop) count <= count + CW'(1);
      else if (do_pop && !do_push) count <= count - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
  import spim_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              clr,
  input  logic              cpol,
  input  logic              cpha_o,
  input  logic              cpha_i,
  input  logic              msb_o,
  input  logic              msb_i,
  input  logic              keep_in,
  input  logic [DIV_W-1:0]  div,
  input  tx_entry_t         tx_head,
  input  logic              tx_empty,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_word,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n,
  output logic              busy,
  output logic [LEN_W-1:0]  bitcnt
);
  sh_state_t         st;
  logic [DIV_W-1:0]  cnt;
  logic              sclk_rel, gap_ph, cur_hold;
  logic [LEN_W-1:0]  cur_len;
  logic [DATA_W-1:0] tx_sh, rx_sh, rx_next, tx_adv;
  logic              tick, last_bit, do_load, done;

  assign tick     = (cnt == div);
  assign last_bit = (bitcnt == cur_len - LEN_W'(1));
  assign rx_next  = msb_i ? {rx_sh[DATA_W-2:0], miso} : {miso, rx_sh[DATA_W-1:1]};
  assign tx_adv   = msb_o ? {tx_sh[DATA_W-2:0], 1'b0} : {1'b0, tx_sh[DATA_W-1:1]};
  assign do_load  = en && !clr && !tx_empty &&
                    ((st == ST_IDLE) || (st == ST_GAP && tick && gap_ph));
  assign done     = en && !clr && (st == ST_SHIFT) && tick && sclk_rel && last_bit;

  assign tx_pop  = do_load;
  assign rx_push = done;
  assign rx_word = cpha_i ? rx_next : rx_sh;
  assign sclk    = cpol ^ sclk_rel;
  assign mosi    = msb_o ? tx_sh[DATA_W-1] : tx_sh[0];
  assign busy    = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; sclk_rel <= 1'b0; gap_ph <= 1'b0;
      cur_hold <= 1'b0; cur_len <= LEN_W'(1); bitcnt <= '0;
      tx_sh <= '0; rx_sh <= '0; cs_n <= 1'b1;
    end else if (clr || !en) begin
      st <= ST_IDLE; cnt <= '0; sclk_rel <= 1'b0; gap_ph <= 1'b0;
      bitcnt <= '0; cs_n <= 1'b1;
    end else if (do_load) begin
      st <= ST_SHIFT; cnt <= '0; sclk_rel <= 1'b0; gap_ph <= 1'b0;
      bitcnt <= '0; cs_n <= 1'b0;
      tx_sh <= tx_head.data; cur_len <= tx_head.len; cur_hold <= tx_head.hold;
      if (!keep_in) rx_sh <= '0;
    end else begin
      case (st)
        ST_SHIFT: begin
          if (tick) begin
            cnt <= '0;
            if (!sclk_rel) begin
              sclk_rel <= 1'b1;
              if (!cpha_i) rx_sh <= rx_next;
              if (cpha_o && bitcnt != '0) tx_sh <= tx_adv;
            end else begin
              sclk_rel <= 1'b0;
              if (cpha_i) rx_sh <= rx_next;
              if (last_bit) begin
                st   <= ST_GAP;
                cs_n <= ~cur_hold;
              end else begin
                bitcnt <= bitcnt + LEN_W'(1);
                if (!cpha_o) tx_sh <= tx_adv;
              end
            end
          end else begin
            cnt <= cnt + DIV_W'(1);
          end
        end
        ST_GAP: begin
          if (tick) begin
            cnt <= '0;
            if (!gap_ph) gap_ph <= 1'b1;
            else begin
              gap_ph <= 1'b0;
              st     <= ST_IDLE;
            end
          end else begin
            cnt <= cnt + DIV_W'(1);
          end
        end
        default: cnt <= '0;
      endcase
    end
  end
endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int DIV_W = 12,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        spi_cs_n,
  output logic        irq
);
  logic [31:0]       ctrl0_q, ctrl1_q;
  logic              clr_p, busy_w;
  tx_entry_t         tx_in, tx_head;
  logic              tx_push, tx_pop, tx_full, tx_empty;
  logic              rx_push, rx_pop, rx_full, rx_empty;
  logic [DATA_W-1:0] rx_in, rx_head;
  logic [CW-1:0]     tx_lvl, rx_lvl;
  logic [LEN_W-1:0]  bitcnt;

  assign clr_p = bus_wr && bus_addr == A_CTRL0 && bus_wdata[C0_CLR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl0_q <= '0;
      ctrl1_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_CTRL0) ctrl0_q <= bus_wdata & ~(32'd1 << C0_CLR);
      if (bus_addr == A_CTRL1) ctrl1_q <= bus_wdata;
    end
  end

  assign tx_push    = bus_wr && (bus_addr == A_DATA || bus_addr == A_HOLD);
  assign tx_in.hold = (bus_addr == A_HOLD);
  assign tx_in.len  = clamp_len(ctrl0_q[C0_VARW] ? bus_wdata[31:24]
                                                 : {2'b00, ctrl0_q[5:0]});
  assign tx_in.data = bus_wdata[DATA_W-1:0];
  assign rx_pop     = bus_rd && bus_addr == A_DATA;

  spim_fifo #(.W($bits(tx_entry_t)), .DEPTH(DEPTH)) u_txq (
    .clk, .rst_n, .clr(clr_p), .push(tx_push), .din(tx_in), .pop(tx_pop),
    .dout(tx_head), .count(tx_lvl), .full(tx_full), .empty(tx_empty));

  spim_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk, .rst_n, .clr(clr_p), .push(rx_push), .din(rx_in), .pop(rx_pop),
    .dout(rx_head), .count(rx_lvl), .full(rx_full), .empty(rx_empty));

  spim_shifter #(.DIV_W(DIV_W)) u_sh (
    .clk, .rst_n, .en(ctrl0_q[C0_EN]), .clr(clr_p),
    .cpol(ctrl0_q[C0_POL]), .cpha_o(ctrl0_q[C0_PHO]), .cpha_i(ctrl0_q[C0_PHI]),
    .msb_o(ctrl0_q[C0_MSBO]), .msb_i(ctrl1_q[C1_MSBI]), .keep_in(ctrl1_q[C1_KEEP]),
    .div(ctrl0_q[31:32-DIV_W]), .tx_head, .tx_empty, .tx_pop,
    .rx_push, .rx_word(rx_in), .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi),
    .cs_n(spi_cs_n), .busy(busy_w), .bitcnt);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL0: bus_rdata = ctrl0_q;
      A_CTRL1: bus_rdata = ctrl1_q;
      A_STAT:  bus_rdata = {8'(tx_lvl), 8'(rx_lvl), 5'd0, tx_full, tx_empty,
                            rx_full, rx_empty, busy_w, 6'(bitcnt)};
      A_PEEK, A_DATA: bus_rdata = rx_empty ? '0 : 32'(rx_head);
      default: bus_rdata = '0;
    endcase
  end

  assign irq = (ctrl1_q[C1_TXEIE] && tx_empty) || (ctrl1_q[C1_IDLIE] && !busy_w);
endmodule

// File: rtl/spim_checker.sv
module spim_checker #(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [7:0]    bus_addr,
  input logic [31:0]   bus_wdata,
  input logic [31:0]   ctrl0_q,
  input logic [31:0]   ctrl1_q,
  input logic [CW-1:0] tx_lvl,
  input logic [CW-1:0] rx_lvl,
  input logic          busy_w,
  input logic          spi_cs_n,
  input logic          spi_sclk,
  input logic          irq
);
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_lvl <= CW'(DEPTH)) && (rx_lvl <= CW'(DEPTH)));

  a_r11_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h00 && bus_wdata[9]) |=>
      (tx_lvl == '0 && rx_lvl == '0 && spi_cs_n));

  a_r12_disabled_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl0_q[11] |=> spi_cs_n);

  a_r5_clock_rests: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_w |-> (spi_sclk == ctrl0_q[7]));

  a_r13_idle_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_w) && ctrl1_q[7]) |-> irq);
endmodule

bind spim_top spim_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .ctrl0_q(ctrl0_q), .ctrl1_q(ctrl1_q),
  .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .busy_w(busy_w),
  .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .irq(irq));

// File: tb/tb_spim_top.sv
module tb_spim_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sclk, spi_mosi, spi_cs_n, irq;

  int checks = 0, failures = 0;
  int cyc = 0, last_edge = 0, gmax = 0, gmin = 0, cs_rises = 0;
  logic mon = 1'b0, have_prev = 1'b0, psclk = 1'b0, pcs = 1'b1;

  always #2 clk = ~clk;

  spim_top dut (.clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata,
    .bus_rdata, .spi_sclk, .spi_mosi, .spi_miso(spi_mosi), .spi_cs_n, .irq);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    psclk <= spi_sclk;
    pcs <= spi_cs_n;
    if (mon && spi_sclk != psclk) begin
      if (have_prev) begin
        if (cyc - last_edge > gmax) gmax <= cyc - last_edge;
        if (gmin == 0 || cyc - last_edge < gmin) gmin <= cyc - last_edge;
      end
      have_prev <= 1'b1;
      last_edge <= cyc;
    end
    if (mon && spi_cs_n && !pcs) cs_rises <= cs_rises + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(8'h08, s);
      if (!s[6] && s[9]) return;
    end
  endtask

  function automatic int eff_len(input logic [7:0] raw);
    if (raw == 0) return 1;
    if (raw > 24) return 24;
    return int'(raw);
  endfunction

  function automatic logic [23:0] exp_rx(input int n, input logic [23:0] d,
                                         input bit msbo, input bit msbi);
    logic [23:0] r = '0;
    for (int i = 0; i < n; i++) begin
      logic b = msbo ? d[23-i] : d[i];
      r = msbi ? {r[22:0], b} : {b, r[23:1]};
    end
    return r;
  endfunction

  // {cpol, cpha, msb_out, msb_in, var_width, count[7:0], payload[23:0]}
  localparam logic [36:0] VEC [7] = '{
    {5'b00111, 8'd8,  24'hA50000},   // R2 R6 mode 0
    {5'b11111, 8'd16, 24'h123400},   // R5 mode 3
    {5'b01001, 8'd8,  24'h0000C3},   // R6 lsb both ways
    {5'b10101, 8'd12, 24'hF0A000},   // R5 R6 mixed order
    {5'b00110, 8'd12, 24'hABC000},   // R3 fixed count
    {5'b00111, 8'd40, 24'h123456},   // R2 clamp high
    {5'b00111, 8'd0,  24'h800000}    // R2 zero count
  };

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] r, r2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h08, r);
    chk(r == 32'h0000_0280, "R1 status", r, 32'h0000_0280);
    chk(spi_cs_n && !spi_sclk && !irq, "R1 pins", {spi_cs_n, spi_sclk, irq}, 3'b100);

    // vector table through loopback
    foreach (VEC[k]) begin
      logic [36:0] v = VEC[k];
      int n = v[32] ? eff_len(v[31:24]) : eff_len({2'b00, v[29:24]});
      logic [31:0] c0 = (32'd1 << 20) | (32'd1 << 11) | (32'(v[32]) << 14)
                      | (32'(v[35]) << 10) | (32'(v[35]) << 8) | (32'(v[36]) << 7)
                      | (32'(v[34]) << 6) | (v[32] ? 32'd0 : 32'(v[29:24]));
      logic [23:0] e = exp_rx(n, v[23:0], v[34], v[33]);
      wr(8'h04, 32'(v[33]) << 1);
      wr(8'h00, c0);
      wr(8'h20, {v[31:24], v[23:0]});
      wait_idle();
      rd(8'h20, r);
      chk(r == 32'(e), "R2 R3 R5 R6 loopback", r, 32'(e));
    end

    // R10 full queue drops, R12 disabled, R13 tx-empty irq
    wr(8'h04, 32'h40);
    wr(8'h00, 32'h0);
    for (int i = 0; i < 5; i++) wr(8'h30, 32'h0811_0000);
    rd(8'h08, r);
    chk(r == 32'h0400_0480, "R10 level/full", r, 32'h0400_0480);
    chk(spi_cs_n == 1'b1, "R12 idle when disabled", 32'(spi_cs_n), 32'd1);
    chk(irq == 1'b0, "R13 irq low with queued data", 32'(irq), 32'd0);
    // R11 clear
    wr(8'h00, 32'h200);
    rd(8'h08, r);
    chk(r == 32'h0000_0280, "R11 clear", r, 32'h0000_0280);
    chk(irq == 1'b1, "R13 irq on tx empty", 32'(irq), 32'd1);

    // R7 R8 R4 hold then release, R9 peek/pop
    wr(8'h04, 32'h2);
    wr(8'h00, 32'h0010_4840);
    gmax = 0; gmin = 0; cs_rises = 0; have_prev = 1'b0; mon = 1'b1;
    wr(8'h30, 32'h085A_0000);
    wr(8'h20, 32'h08C3_0000);
    wait_idle();
    repeat (2) @(negedge clk);
    mon = 1'b0;
    chk(cs_rises == 1, "R7 one release over held frame", 32'(cs_rises), 32'd1);
    chk(gmax == 6, "R8 extra idle period", 32'(gmax), 32'd6);
    chk(gmin == 2, "R4 half period", 32'(gmin), 32'd2);
    rd(8'h0C, r);
    rd(8'h08, r2);
    chk(r == 32'h5A && r2[23:16] == 8'd2, "R9 peek keeps entry", {r[15:0], r2[23:16], 8'h0}, 32'h005A_0200);
    rd(8'h20, r);
    chk(r == 32'h5A, "R9 pop first", r, 32'h5A);
    rd(8'h20, r);
    chk(r == 32'hC3, "R9 pop second", r, 32'hC3);
    rd(8'h20, r);
    chk(r == 32'h0, "R9 empty reads zero", r, 32'h0);

    // R7 hold leaves cs low, R12 disable deselects
    wr(8'h30, 32'h0801_0000);
    wait_idle();
    chk(spi_cs_n == 1'b0, "R7 hold keeps select", 32'(spi_cs_n), 32'd0);
    rd(8'h20, r);
    wr(8'h00, 32'h0010_4040);
    @(negedge clk);
    chk(spi_cs_n == 1'b1, "R12 disable deselects", 32'(spi_cs_n), 32'd1);

    // R14 keep-input accumulation
    wr(8'h04, 32'h3);
    wr(8'h00, 32'h0010_4840);
    wr(8'h20, 32'h08A5_0000);
    wait_idle();
    wr(8'h20, 32'h083C_0000);
    wait_idle();
    rd(8'h20, r);
    chk(r[7:0] == 8'hA5, "R14 first entry", 32'(r[7:0]), 32'hA5);
    rd(8'h20, r);
    chk(r[15:0] == 16'hA53C, "R14 accumulated", 32'(r[15:0]), 32'hA53C);

    // R13 idle irq
    wr(8'h04, 32'h80);
    @(negedge clk);
    chk(irq == 1'b1, "R13 idle irq", 32'(irq), 32'd1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule